// File: doc/BRIEF.md
# Host interrupt request controller

This block sits in a peripheral that answers a host over a byte-serial, host-clocked link with an SPI-like shape: chip select low, data shifted out MSB first, and the host sampling on the rising serial clock. The block drives an active-low interrupt request line that tells the host when outgoing bytes wait in a 16-entry queue. Bytes reach the queue through two push ports. The solicited port carries replies to a host read request. The unsolicited port carries spontaneous events, and it accepts them only while unsolicited mode is on.

The line follows two modes. With unsolicited mode off, the line is asserted only after a read-request strobe has armed it and data is waiting. With unsolicited mode on, any queued byte asserts it. During the final byte of a read, the release and any re-assertion are tied to the serial clock count inside that byte. The release happens on the 7th rising edge (N-1). A byte queued after that edge produces a one-period high pulse, and the line drops again on the 8th edge (N). Bits are counted with a 3-bit counter that clears while chip select is high.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, irq_no is high, miso_o is 0, err_o is 0, the queue is empty and no read request is pending.
- R2: With uns_en_i low, irq_no goes low one clock after the first cycle in which a read request has been seen and the queue is non-empty. A queued byte with no read request leaves irq_no high.
- R3: With uns_en_i low, once irq_no has been released at the end of a read, it stays high even if bytes are queued, until rd_req_i is pulsed again.
- R4: With uns_en_i high, an accepted unsolicited push makes irq_no low one clock later, with no read request needed.
- R5: While the last queued byte is shifted out, irq_no stays low through serial rising edges 1 to 6 of that byte. It goes high one clock after rising edge 7 (N-1), and stays high until rising edge 8 (N).
- R6: If a byte is queued before rising edge 7 of what was the final byte, irq_no stays low across that whole byte.
- R7: If a byte is queued after rising edge 7 and before rising edge 8 of the final byte, irq_no is high in that window and goes low one clock after rising edge 8.
- R8: miso_o presents bit (7-k) of the head byte after k rising edges of sclk_i within the byte. The byte is popped on the 8th rising edge. Raising cs_ni clears the bit count without popping.
- R9: Reading while the queue is empty shifts out 0x00 and leaves irq_no unchanged.
- R10: An unsolicited push while uns_en_i is low is dropped, and err_o is high for exactly the following clock.
- R11: The queue holds 16 bytes, and pushes into a full queue are dropped. When both push ports fire in one cycle, the solicited byte is queued ahead of the unsolicited one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; serial inputs are synchronous to it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uns_en_i | input | 1 | Unsolicited mode enable |
| rd_req_i | input | 1 | One-cycle strobe: host read request decoded |
| sol_push_i | input | 1 | Push a solicited reply byte |
| sol_data_i | input | 8 | Solicited byte |
| uns_push_i | input | 1 | Push an unsolicited event byte |
| uns_data_i | input | 8 | Unsolicited byte |
| sclk_i | input | 1 | Host serial clock level |
| cs_ni | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to host |
| irq_no | output | 1 | Active-low interrupt request line |
| err_o | output | 1 | One-cycle pulse on a dropped unsolicited push |

## Verification
A wrong queue count appears at the ports within one byte time. Either irq_no fails to release on edge 7 of the real last byte, or it releases on a byte that is not the last, and the scoreboard compares the shifted bytes in order. A hold flag that is stuck or lost shows up as irq_no dropping low between edges 7 and 8, or staying high after edge 8, and a sample after each rising edge catches it. A read-request flag that fails to clear shows up as irq_no going low on a solicited push with no new request.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int Q_DEPTH = 16;
  typedef logic [BYTE_W-1:0] msg_byte_t;
endpackage

// File: rtl/hirq_fifo.sv
module hirq_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_push_i,
  input  logic [W-1:0]     a_data_i,
  input  logic             b_push_i,
  input  logic [W-1:0]     b_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             a_ok, b_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  // port a has priority for the free slots
  assign a_ok   = a_push_i && (cnt_q < CNT_W'(DEPTH));
  assign b_ok   = b_push_i && (({1'b0, cnt_q} + (CNT_W+1)'(a_ok)) < (CNT_W+1)'(DEPTH));
  assign pop_ok = pop_i && (cnt_q != '0);

  assign cnt_nxt_o = cnt_q + CNT_W'(a_ok) + CNT_W'(b_ok) - CNT_W'(pop_ok);
  assign head_o    = mem[rd_q];
  assign empty_o   = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (a_ok) mem[wr_q] <= a_data_i;
    if (b_ok) mem[ptr_add(wr_q, {1'b0, a_ok})] <= b_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= ptr_add(wr_q, {1'b0, a_ok} + {1'b0, b_ok});
      if (pop_ok) rd_q <= ptr_add(rd_q, 2'd1);
      cnt_q <= cnt_nxt_o;
    end
  end

  // R11
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R11
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH) && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/hirq_bitclk.sv
module hirq_bitclk #(
  parameter int W = 8,
  localparam int BC_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         cs_ni,
  input  logic [W-1:0] head_i,
  input  logic         empty_i,
  output logic         miso_o,
  output logic         pop_o,
  output logic         edge_n1_o,
  output logic         edge_n_o
);
  logic            sclk_q, rise;
  logic [BC_W-1:0] bit_q, sel;

  assign rise      = sclk_i && !sclk_q && !cs_ni;
  assign edge_n1_o = rise && (bit_q == BC_W'(W-2));
  assign edge_n_o  = rise && (bit_q == BC_W'(W-1));
  assign pop_o     = edge_n_o && !empty_i;
  assign sel       = BC_W'(W-1) - bit_q;
  assign miso_o    = empty_i ? 1'b0 : head_i[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      bit_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (cs_ni)     bit_q <= '0;
      else if (rise) bit_q <= bit_q + 1'b1;
    end
  end

  // R8
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_q == '0));
endmodule

// File: rtl/hirq_line.sv
module hirq_line #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uns_en_i,
  input  logic             rd_req_i,
  input  logic             cs_ni,
  input  logic             edge_n1_i,
  input  logic             edge_n_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             irq_o
);
  logic hold_q, hold_d, armed_q, armed_d, irq_q, irq_d, final_rel;

  // clock N-1 of the only remaining byte, nothing new arrived
  assign final_rel = edge_n1_i && (cnt_nxt_i == CNT_W'(1));

  always_comb begin
    hold_d = hold_q;
    if (cs_ni)          hold_d = 1'b0;
    else if (final_rel) hold_d = 1'b1;
    else if (edge_n_i)  hold_d = 1'b0;
    armed_d = armed_q;
    if (final_rel) armed_d = 1'b0;
    if (rd_req_i)  armed_d = 1'b1;
    irq_d = !hold_d && (cnt_nxt_i != '0) && (uns_en_i || armed_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R5
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !cs_ni && !edge_n_i) |=> !irq_q);

  // R7
  reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !cs_ni && edge_n_i && uns_en_i && cnt_nxt_i != '0) |=> irq_q);

  // R3
  solicit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uns_en_i && !armed_q && !rd_req_i) |=> !irq_q);

  // R4
  unsol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uns_en_i && !hold_q && !edge_n1_i && !edge_n_i && cnt_nxt_i != '0) |=> irq_q);
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int DEPTH = Q_DEPTH,
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         uns_en_i,
  input  logic         rd_req_i,
  input  logic         sol_push_i,
  input  logic [W-1:0] sol_data_i,
  input  logic         uns_push_i,
  input  logic [W-1:0] uns_data_i,
  input  logic         sclk_i,
  input  logic         cs_ni,
  output logic         miso_o,
  output logic         irq_no,
  output logic         err_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     head;
  logic             empty, pop, edge_n1, edge_n, irq, err_q;
  logic [CNT_W-1:0] cnt_nxt;

  hirq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i, .rst_ni,
    .a_push_i (sol_push_i),
    .a_data_i (sol_data_i),
    .b_push_i (uns_push_i && uns_en_i),
    .b_data_i (uns_data_i),
    .pop_i    (pop),
    .head_o   (head),
    .empty_o  (empty),
    .cnt_nxt_o(cnt_nxt)
  );

  hirq_bitclk #(.W(W)) u_bitclk (
    .clk_i, .rst_ni, .sclk_i, .cs_ni,
    .head_i   (head),
    .empty_i  (empty),
    .miso_o,
    .pop_o    (pop),
    .edge_n1_o(edge_n1),
    .edge_n_o (edge_n)
  );

  hirq_line #(.CNT_W(CNT_W)) u_line (
    .clk_i, .rst_ni, .uns_en_i, .rd_req_i, .cs_ni,
    .edge_n1_i(edge_n1),
    .edge_n_i (edge_n),
    .cnt_nxt_i(cnt_nxt),
    .irq_o    (irq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= uns_push_i && !uns_en_i;
  end

  assign irq_no = !irq;
  assign err_o  = err_q;

  // R10
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uns_push_i && !uns_en_i) |=> err_o);
endmodule

// File: tb/host_irq_ctrl_tb.sv
module host_irq_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       uns_en = 1'b0, rd_req = 1'b0, sol_push = 1'b0, uns_push = 1'b0;
  logic [7:0] sol_data = '0, uns_data = '0;
  logic       sclk = 1'b0, cs_n = 1'b1;
  logic       miso, irq_n, err;

  int         nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  logic       irq_hist [8];
  logic       irq_win;
  logic [7:0] got;

  always #4 clk = !clk;

  host_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uns_en_i(uns_en), .rd_req_i(rd_req),
    .sol_push_i(sol_push), .sol_data_i(sol_data),
    .uns_push_i(uns_push), .uns_data_i(uns_data),
    .sclk_i(sclk), .cs_ni(cs_n), .miso_o(miso), .irq_no(irq_n), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv_sol(input logic [7:0] d);
    sol_push = 1'b1; sol_data = d;
    @(negedge clk);
    sol_push = 1'b0;
    if (exp_q.size() < 16) exp_q.push_back(d);
  endtask

  task automatic drv_uns(input logic [7:0] d);
    uns_push = 1'b1; uns_data = d;
    @(negedge clk);
    uns_push = 1'b0;
    if (uns_en && exp_q.size() < 16) exp_q.push_back(d);
  endtask

  task automatic pulse_rd_req();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // shifts one byte; optional unsolicited push before rising edge push_at+1
  task automatic spi_byte(input int push_at, input logic [7:0] pd, output logic [7:0] g);
    g = '0;
    for (int b = 0; b < 8; b++) begin
      sclk = 1'b0;
      @(negedge clk);
      if (push_at == b) begin
        drv_uns(pd);
        irq_win = irq_n;
      end
      @(negedge clk);
      g = {g[6:0], miso};
      sclk = 1'b1;
      @(negedge clk);
      irq_hist[b] = irq_n;
    end
    sclk = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor: expected byte taken from the front of the queue
  task automatic read_chk(input int push_at, input logic [7:0] pd, input string req);
    logic [7:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
    spi_byte(push_at, pd, got);
    check(got == e, req, got, e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq_n == 1'b1, "R1 irq", irq_n, 1);
    check(miso == 1'b0, "R1 miso", miso, 0);
    check(err == 1'b0, "R1 err", err, 0);

    // R2 solicited: byte alone does not assert
    drv_sol(8'hA5);
    @(negedge clk);
    check(irq_n == 1'b1, "R2 no request", irq_n, 1);
    pulse_rd_req();
    check(irq_n == 1'b0, "R2 after request", irq_n, 0);
    cs_n = 1'b0;
    read_chk(-1, 8'h00, "R8 data A5");
    check(irq_hist[5] == 1'b0, "R5 low before N-1", irq_hist[5], 0);
    check(irq_hist[6] == 1'b1, "R5 high at N-1", irq_hist[6], 1);
    check(irq_hist[7] == 1'b1, "R5 high after N", irq_hist[7], 1);
    cs_n = 1'b1;
    @(negedge clk);

    // R3 released line stays high until a new request
    drv_sol(8'h3C);
    repeat (4) @(negedge clk);
    check(irq_n == 1'b1, "R3 no re-request", irq_n, 1);
    pulse_rd_req();
    check(irq_n == 1'b0, "R3 re-request", irq_n, 0);
    drv_sol(8'h5A);
    cs_n = 1'b0;
    read_chk(-1, 8'h00, "R8 data 3C");
    check(irq_hist[6] == 1'b0 && irq_hist[7] == 1'b0, "R6 not final byte", irq_hist[6], 0);
    read_chk(-1, 8'h00, "R8 data 5A");
    check(irq_hist[6] == 1'b1, "R5 final release", irq_hist[6], 1);
    cs_n = 1'b1;
    @(negedge clk);

    // R4 unsolicited mode
    uns_en = 1'b1;
    @(negedge clk);
    drv_uns(8'h81);
    check(irq_n == 1'b0, "R4 unsolicited assert", irq_n, 0);
    cs_n = 1'b0;
    read_chk(3, 8'h42, "R8 data 81");
    check(irq_hist[6] == 1'b0 && irq_hist[7] == 1'b0, "R6 early arrival", irq_hist[6], 0);
    read_chk(7, 8'h99, "R8 data 42");
    check(irq_hist[6] == 1'b1, "R7 released at N-1", irq_hist[6], 1);
    check(irq_win == 1'b1, "R7 high in window", irq_win, 1);
    check(irq_hist[7] == 1'b0, "R7 low at N", irq_hist[7], 0);
    read_chk(-1, 8'h00, "R8 data 99");
    check(irq_hist[7] == 1'b1, "R5 drained", irq_hist[7], 1);

    // R9 empty read
    read_chk(-1, 8'h00, "R9 empty data");
    check((irq_hist[0] & irq_hist[3] & irq_hist[6] & irq_hist[7]) == 1'b1, "R9 line unchanged", irq_hist[7], 1);
    cs_n = 1'b1;
    @(negedge clk);

    // R10 dropped unsolicited push
    uns_en = 1'b0;
    @(negedge clk);
    drv_uns(8'h77);
    check(err == 1'b1, "R10 err pulse", err, 1);
    @(negedge clk);
    check(err == 1'b0, "R10 err one cycle", err, 0);
    check(irq_n == 1'b1, "R10 line untouched", irq_n, 1);
    cs_n = 1'b0;
    read_chk(-1, 8'h00, "R10 byte dropped");
    cs_n = 1'b1;
    @(negedge clk);

    // R11 ordering and capacity
    uns_en = 1'b1;
    sol_push = 1'b1; sol_data = 8'h11; uns_push = 1'b1; uns_data = 8'h22;
    @(negedge clk);
    sol_push = 1'b0; uns_push = 1'b0;
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h22);
    for (int i = 0; i < 14; i++) drv_sol(8'h30 + 8'(i));
    drv_sol(8'hEE);
    // R8 partial byte then deselect
    cs_n = 1'b0;
    for (int b = 0; b < 3; b++) begin
      sclk = 1'b0; @(negedge clk); @(negedge clk);
      sclk = 1'b1; @(negedge clk);
    end
    sclk = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 17; i++) read_chk(-1, 8'h00, "R11 order/capacity");
    check(irq_n == 1'b1, "R11 drained", irq_n, 1);
    cs_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule